// File: doc/BRIEF.md
# Open-Row Tracking SDRAM Command Sequencer

This block sits between a simple request master and the command pins of a DDR SDRAM. Each request names a bank, a row, a starting column and a direction, and arrives through a valid/ready handshake. The sequencer turns it into the shortest legal command sequence. It keeps a table with one entry per bank that records whether a row is open in that bank and which row it is.

A request that hits the open row of its bank goes straight to READ or WRITE. A request to a bank with no open row gets an ACTIVE first. A request to a bank with a different row open gets a PRECHARGE, then an ACTIVE, then the column command. The row-to-column gap (T_RCD) and the precharge-to-activate gap (T_RP) are constant parameters.

A configuration input selects a burst of 4 or 8 beats. Column commands, and any precharge, are held back until the running burst has finished its data beats. The data path, strobes, refresh, initialization and mode programming live elsewhere.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins show NOP, `reqReady` is 1, and every bank is closed, so the first request to any bank starts with ACTIVE. A reset asserted later clears every open-row entry in the same way.
- R2: A request to a closed bank is accepted and drives ACTIVE on the next cycle, with `memBa` set to the bank and `memAddr` set to the row. The column command follows exactly T_RCD cycles after the ACTIVE.
- R3: A request whose row is already open in its bank drives READ or WRITE on the cycle after it is accepted, with no ACTIVE before it.
- R4: A request to a bank that has a different row open drives PRECHARGE (`memBa` = bank, `memAddr` = 0, so address bit 10 is 0 and only that bank is closed). ACTIVE of the new row follows exactly T_RP cycles later, and the column command follows T_RCD cycles after that. The PRECHARGE is held back until the running burst's beats have finished.
- R5: A column command carries the bank on `memBa` and the start column zero-extended on `memAddr`, so address bit 10 is 0. It is READ when `reqWrite` is 0 and WRITE when `reqWrite` is 1.
- R6: Two column commands are at least BL/2 cycles apart, where BL is 4 when `burstLen8` is 0 and 8 when it is 1; that is 2 and 4 cycles. A hit that waits for this spacing issues its column command exactly at the end of it.
- R7: Pin codes, in the order {csN, rasN, casN, weN}, are: NOP 0111, ACTIVE 0011, PRECHARGE 0010, READ 0101, WRITE 0100. Every cycle without a command shows NOP.
- R8: Opening, closing or reopening a row in one bank leaves the recorded open row of every other bank unchanged.
- R9: `reqReady` is 0 from the cycle after a miss or a conflict is accepted until its column command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_BITS | Target bank |
| reqRow | input | ROW_BITS | Target row |
| reqCol | input | COL_BITS | Burst start column |
| burstLen8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | BANK_BITS | Bank address |
| memAddr | output | ROW_BITS | Multiplexed row / column address |

## Verification
The main function is tried with four kinds of request. A request to a closed bank shows whether the ACTIVE happens and how long the row-to-column gap is. A request to the open row shows that the ACTIVE is skipped. A request to a different row shows the precharge, activate and column order and its two gaps. A request to another bank shows that the banks are tracked separately. Back-to-back hits with 4-beat and with 8-beat bursts tell the two spacing values apart. A conflict placed directly behind an 8-beat burst shows that the precharge is held back. A reset in the middle of the run followed by a request to a previously open row shows whether the table was cleared.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2,
    CMD_COL = 2'd3
  } seq_cmd_e;

  typedef struct packed {
    logic     load;
    seq_cmd_e cmd;
  } seq_strobe_t;

  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_ACT = 4'b0011;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_RD  = 4'b0101;
  localparam logic [3:0] PIN_WR  = 4'b0100;
endpackage

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int T_RCD         = 3,
  parameter int T_RP          = 3,
  parameter int BEATS_PER_CLK = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        burstLen8,
  input  logic        bankOpen,
  input  logic        rowHit,
  output logic        reqReady,
  output seq_strobe_t strobe
);
  localparam int WAIT_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int GAP4     = 4 / BEATS_PER_CLK - 1;
  localparam int GAP8     = 8 / BEATS_PER_CLK - 1;
  localparam int GAP_W    = $clog2(GAP8 + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE_HOLD, ST_PRE_WAIT, ST_COL_WAIT} state_e;

  state_e            state, stateNext;
  logic [WAIT_W-1:0] waitCnt, waitNext;
  logic [GAP_W-1:0]  gapCnt;
  logic              gapFree;

  assign gapFree  = (gapCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext   = state;
    waitNext    = (waitCnt != '0) ? waitCnt - 1'b1 : waitCnt;
    strobe.load = 1'b0;
    strobe.cmd  = CMD_NOP;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (rowHit) begin
            if (gapFree) strobe.cmd = CMD_COL;
            else begin
              stateNext = ST_COL_WAIT;
              waitNext  = '0;
            end
          end else if (!bankOpen) begin
            strobe.cmd = CMD_ACT;
            waitNext   = WAIT_W'(T_RCD - 1);
            stateNext  = ST_COL_WAIT;
          end else if (gapFree) begin
            strobe.cmd = CMD_PRE;
            waitNext   = WAIT_W'(T_RP - 1);
            stateNext  = ST_PRE_WAIT;
          end else begin
            stateNext = ST_PRE_HOLD;
          end
        end
      end
      ST_PRE_HOLD: begin
        if (gapFree) begin
          strobe.cmd = CMD_PRE;
          waitNext   = WAIT_W'(T_RP - 1);
          stateNext  = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (waitCnt == '0) begin
          strobe.cmd = CMD_ACT;
          waitNext   = WAIT_W'(T_RCD - 1);
          stateNext  = ST_COL_WAIT;
        end
      end
      ST_COL_WAIT: begin
        if (waitCnt == '0 && gapFree) begin
          strobe.cmd = CMD_COL;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      gapCnt  <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitNext;
      if (strobe.cmd == CMD_COL)
        gapCnt <= burstLen8 ? GAP_W'(GAP8) : GAP_W'(GAP4);
      else if (!gapFree)
        gapCnt <= gapCnt - 1'b1;
    end
  end

  // R9: a miss or conflict keeps the handshake closed on the next cycle
  p_busy_after_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !rowHit |=> !reqReady);
  // R4: precharge never cuts a running burst
  p_pre_after_burst_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmd == CMD_PRE |-> gapCnt == '0);
endmodule

// File: rtl/sdseq_dpath.sv
module sdseq_dpath
  import sdseq_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int ROW_BITS  = 14,
  parameter int COL_BITS  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          strobe,
  input  logic                 reqWrite,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  output logic                 bankOpen,
  output logic                 rowHit,
  output logic                 memCsN,
  output logic                 memRasN,
  output logic                 memCasN,
  output logic                 memWeN,
  output logic [BANK_BITS-1:0] memBa,
  output logic [ROW_BITS-1:0]  memAddr
);
  localparam int NUM_BANKS = 1 << BANK_BITS;

  logic                 heldWrite;
  logic [BANK_BITS-1:0] heldBank;
  logic [ROW_BITS-1:0]  heldRow;
  logic [COL_BITS-1:0]  heldCol;

  logic                 selWrite;
  logic [BANK_BITS-1:0] selBank;
  logic [ROW_BITS-1:0]  selRow;
  logic [COL_BITS-1:0]  selCol;

  logic [NUM_BANKS-1:0] openVld;
  logic [ROW_BITS-1:0]  openRow [NUM_BANKS];

  assign selWrite = strobe.load ? reqWrite : heldWrite;
  assign selBank  = strobe.load ? reqBank  : heldBank;
  assign selRow   = strobe.load ? reqRow   : heldRow;
  assign selCol   = strobe.load ? reqCol   : heldCol;

  assign bankOpen = openVld[selBank];
  assign rowHit   = bankOpen && (openRow[selBank] == selRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWrite <= 1'b0;
      heldBank  <= '0;
      heldRow   <= '0;
      heldCol   <= '0;
    end else if (strobe.load) begin
      heldWrite <= reqWrite;
      heldBank  <= reqBank;
      heldRow   <= reqRow;
      heldCol   <= reqCol;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openVld[b] <= 1'b0;
        openRow[b] <= '0;
      end else if (selBank == BANK_BITS'(b)) begin
        if (strobe.cmd == CMD_ACT) begin
          openVld[b] <= 1'b1;
          openRow[b] <= selRow;
        end else if (strobe.cmd == CMD_PRE) begin
          openVld[b] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {memCsN, memRasN, memCasN, memWeN} <= PIN_NOP;
      memBa   <= '0;
      memAddr <= '0;
    end else begin
      unique case (strobe.cmd)
        CMD_ACT: begin
          {memCsN, memRasN, memCasN, memWeN} <= PIN_ACT;
          memBa   <= selBank;
          memAddr <= selRow;
        end
        CMD_PRE: begin
          {memCsN, memRasN, memCasN, memWeN} <= PIN_PRE;
          memBa   <= selBank;
          memAddr <= '0;
        end
        CMD_COL: begin
          {memCsN, memRasN, memCasN, memWeN} <= selWrite ? PIN_WR : PIN_RD;
          memBa   <= selBank;
          memAddr <= ROW_BITS'(selCol);
        end
        default: {memCsN, memRasN, memCasN, memWeN} <= PIN_NOP;
      endcase
    end
  end

  // R2: an activate only goes to a bank the table holds closed
  p_act_closed_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmd == CMD_ACT |-> !bankOpen);
  // R3: a column command only goes to the row that is open
  p_col_open_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmd == CMD_COL |-> rowHit);
  // R4: a precharge only closes a bank holding some other row
  p_pre_conflict_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmd == CMD_PRE |-> bankOpen && !rowHit);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int BANK_BITS     = 3,
  parameter int ROW_BITS      = 14,
  parameter int COL_BITS      = 10,
  parameter int T_RCD         = 3,
  parameter int T_RP          = 3,
  parameter int BEATS_PER_CLK = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  input  logic                 burstLen8,
  output logic                 memCsN,
  output logic                 memRasN,
  output logic                 memCasN,
  output logic                 memWeN,
  output logic [BANK_BITS-1:0] memBa,
  output logic [ROW_BITS-1:0]  memAddr
);
  seq_strobe_t strobe;
  logic        bankOpen, rowHit;

  sdseq_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .BEATS_PER_CLK(BEATS_PER_CLK)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .burstLen8(burstLen8),
    .bankOpen(bankOpen), .rowHit(rowHit), .reqReady(reqReady), .strobe(strobe)
  );

  sdseq_dpath #(.BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .bankOpen(bankOpen), .rowHit(rowHit),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBa(memBa), .memAddr(memAddr)
  );

  // Pin-level timing monitors for the assertions below
  logic [3:0]           pinCode;
  logic [7:0]           actAge, preAge;
  logic [BANK_BITS-1:0] actBank, preBank;
  logic                 pinCol;

  assign pinCode = {memCsN, memRasN, memCasN, memWeN};
  assign pinCol  = (pinCode == PIN_RD) || (pinCode == PIN_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAge  <= 8'hFF;
      preAge  <= 8'hFF;
      actBank <= '0;
      preBank <= '0;
    end else begin
      if (pinCode == PIN_ACT) begin
        actAge  <= 8'd1;
        actBank <= memBa;
      end else if (actAge != 8'hFF) actAge <= actAge + 8'd1;
      if (pinCode == PIN_PRE) begin
        preAge  <= 8'd1;
        preBank <= memBa;
      end else if (preAge != 8'hFF) preAge <= preAge + 8'd1;
    end
  end

  // R7: only the five legal codes ever appear
  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    pinCode == PIN_NOP || pinCode == PIN_ACT || pinCode == PIN_PRE ||
    pinCode == PIN_RD  || pinCode == PIN_WR);
  // R6: no two column commands in adjacent cycles
  p_col_spacing_r6: assert property (@(posedge clk) disable iff (!rstN)
    pinCol |=> !pinCol);
  // R2: row-to-column gap respected at the pins
  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    pinCol && memBa == actBank |-> actAge >= 8'(T_RCD));
  // R4: precharge-to-activate gap respected at the pins
  p_rp_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    pinCode == PIN_ACT && memBa == preBank |-> preAge >= 8'(T_RP));
endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
module sdram_cmd_seq_tb_top;
  localparam int BB = 3, RB = 14, CB = 10, TRCD = 3, TRP = 3;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_PRE = 4'b0010,
                         C_RD = 4'b0101, C_WR = 4'b0100;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, burstLen8 = 1'b0;
  logic [BB-1:0] reqBank = '0;
  logic [RB-1:0] reqRow = '0;
  logic [CB-1:0] reqCol = '0;
  logic reqReady, memCsN, memRasN, memCasN, memWeN;
  logic [BB-1:0] memBa;
  logic [RB-1:0] memAddr;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_seq #(.BANK_BITS(BB), .ROW_BITS(RB), .COL_BITS(CB), .T_RCD(TRCD), .T_RP(TRP)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .burstLen8(burstLen8),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBa(memBa), .memAddr(memAddr)
  );

  function automatic logic [3:0] code();
    return {memCsN, memRasN, memCasN, memWeN};
  endfunction

  task automatic checkCmd(string tag, logic [3:0] expCode, int expBa, int expAddr);
    total++;
    if (code() !== expCode || memBa !== BB'(expBa) || memAddr !== RB'(expAddr)) begin
      bad++;
      $display("FAIL %s: pins=%b ba=%0d addr=%h expected pins=%b ba=%0d addr=%h",
               tag, code(), memBa, memAddr, expCode, expBa, expAddr);
    end
  endtask

  task automatic checkCode(string tag, logic [3:0] expCode);
    total++;
    if (code() !== expCode) begin
      bad++;
      $display("FAIL %s: pins=%b expected %b", tag, code(), expCode);
    end
  endtask

  task automatic checkReady(string tag, logic exp);
    total++;
    if (reqReady !== exp) begin
      bad++;
      $display("FAIL %s: reqReady=%b expected %b", tag, reqReady, exp);
    end
  endtask

  task automatic nops(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkCode(tag, C_NOP);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the negedge after the accepting clock edge
  task automatic sendReq(logic wr, int bank, int row, int col);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqBank = BB'(bank); reqRow = RB'(row); reqCol = CB'(col);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    checkCode("R1 reset pins NOP", C_NOP);
    checkReady("R1 ready after reset", 1'b1);
  endtask

  task automatic testMiss();
    sendReq(1'b0, 2, 'h123, 'h40);
    checkCmd("R2 activate bank/row", C_ACT, 2, 'h123);
    checkReady("R9 busy after miss", 1'b0);
    nops("R7 nop during tRCD", TRCD - 1);
    @(negedge clk);
    checkCmd("R5 read bank/col", C_RD, 2, 'h40);
    checkReady("R9 ready after column", 1'b1);
  endtask

  task automatic testHit();
    idle(4);
    sendReq(1'b1, 2, 'h123, 'h3F8);
    checkCmd("R3 hit write without activate", C_WR, 2, 'h3F8);
  endtask

  task automatic testConflict();
    idle(4);
    sendReq(1'b0, 2, 'h55, 'h8);
    checkCmd("R4 precharge bank", C_PRE, 2, 0);
    checkReady("R9 busy after conflict", 1'b0);
    nops("R4 nop during tRP", TRP - 1);
    @(negedge clk);
    checkCmd("R4 activate new row", C_ACT, 2, 'h55);
    nops("R4 nop during tRCD", TRCD - 1);
    @(negedge clk);
    checkCmd("R4 column after reopen", C_RD, 2, 'h8);
  endtask

  task automatic testBankIndep();
    idle(4);
    sendReq(1'b0, 5, 'h2AA, 'h1);
    checkCmd("R8 other bank activates", C_ACT, 5, 'h2AA);
    nops("R8 nop", TRCD - 1);
    @(negedge clk);
    checkCmd("R8 other bank read", C_RD, 5, 'h1);
    idle(4);
    sendReq(1'b1, 2, 'h55, 'h22);
    checkCmd("R8 first bank row still open", C_WR, 2, 'h22);
  endtask

  task automatic testGap(logic bl8);
    int half;
    half = bl8 ? 4 : 2;
    burstLen8 = bl8;
    idle(4);
    sendReq(1'b0, 2, 'h55, 'h10);
    checkCmd("R6 first column", C_RD, 2, 'h10);
    sendReq(1'b1, 2, 'h55, 'h18);
    checkCode("R6 spacing nop", C_NOP);
    nops("R6 spacing nop", half - 2);
    @(negedge clk);
    checkCmd(bl8 ? "R6 second column after 4 cycles" : "R6 second column after 2 cycles",
             C_WR, 2, 'h18);
  endtask

  task automatic testPreHold();
    burstLen8 = 1'b1;
    idle(4);
    sendReq(1'b0, 2, 'h55, 'h30);
    checkCmd("R4 burst before conflict", C_RD, 2, 'h30);
    sendReq(1'b0, 2, 'h66, 'h4);
    checkCode("R4 precharge held", C_NOP);
    nops("R4 precharge held", 2);
    @(negedge clk);
    checkCmd("R4 precharge after burst", C_PRE, 2, 0);
    nops("R4 nop tRP", TRP - 1);
    @(negedge clk);
    checkCmd("R4 activate after hold", C_ACT, 2, 'h66);
    nops("R4 nop tRCD", TRCD - 1);
    @(negedge clk);
    checkCmd("R4 column after hold", C_RD, 2, 'h4);
    burstLen8 = 1'b0;
  endtask

  task automatic testResetClears();
    idle(4);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    checkCode("R1 pins NOP after late reset", C_NOP);
    checkReady("R1 ready after late reset", 1'b1);
    sendReq(1'b0, 2, 'h66, 'h7);
    checkCmd("R1 table cleared, activate again", C_ACT, 2, 'h66);
    nops("R1 nop", TRCD - 1);
    @(negedge clk);
    checkCmd("R1 column after reopen", C_RD, 2, 'h7);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMiss();
    testHit();
    testConflict();
    testBankIndep();
    testGap(1'b0);
    testGap(1'b1);
    testPreHold();
    testResetClears();
    idle(3);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule